// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a 6-bit count taken from a register. Every count from 0 to 63 has a defined result and carry. The result is not reduced modulo the word width. A count of 32 or more empties the word for logical shifts and floods it with the sign for arithmetic shifts. Beside the result, the block returns a carry flag (the last bit shifted out), an extend flag that copies the carry, and negative, zero and overflow flags for the result.

The shift path is pure logic and is captured in one register stage. When `op_valid` is high, the result and flags for that cycle's operands appear on the outputs after the next clock edge, and `out_valid` pulses for that cycle. The caller feeds the carry flag of the last instruction into `carry_in`. A zero count passes that value through, so the carry history survives a shift that moves no bits.

Top module: `bshift_top`

## Requirements
- R1: `kind` selects the operation: 2'b00 shifts left, 2'b01 shifts right logically, 2'b10 shifts right arithmetically, and 2'b11 acts exactly like 2'b00.
- R2: A count of 0 returns the operand unchanged, and carry equals `carry_in`, for every kind.
- R3: A left shift by n in 1..31 gives operand<<n, with carry equal to operand bit (32-n).
- R4: A logical right shift by n in 1..31 gives operand>>n with zero fill, with carry equal to operand bit (n-1).
- R5: A logical shift by exactly 32 gives a zero result, with carry equal to operand bit 0 for a left shift and operand bit 31 for a right shift.
- R6: A logical shift by 33..63 gives a zero result and a zero carry, in both directions.
- R7: An arithmetic right shift by n in 1..31 fills the vacated bits with operand bit 31, and carry is operand bit (n-1). For n of 32 or more, every result bit and the carry equal operand bit 31.
- R8: The extend flag always equals the carry flag.
- R9: `neg` equals result bit 31 and `zero` is set exactly when the result is 0. `ovf` is always 0.
- R10: Outputs change only on the clock edge at which `op_valid` is high. `out_valid` is high for the one cycle after that edge, and the outputs hold their values while `op_valid` is low.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| op_valid | input | 1 | Operands are valid; the output register loads |
| operand | input | 32 | Value to shift |
| count | input | 6 | Shift count, 0..63 |
| kind | input | 2 | Shift kind select |
| carry_in | input | 1 | Previous carry flag |
| out_valid | output | 1 | Outputs were loaded on the last edge |
| result | output | 32 | Shifted value |
| carry | output | 1 | Carry flag |
| extend | output | 1 | Extend flag |
| neg | output | 1 | Result is negative |
| zero | output | 1 | Result is zero |
| ovf | output | 1 | Overflow flag, held clear |

## Verification
The assertions assume that operands, count, kind and `carry_in` are stable and known on every edge at which `op_valid` is high. They also assume that the block leaves reset at least one edge before its first operation, so that each `$past` sample is a real operation. The bench changes inputs only on the falling edge and raises `op_valid` only after the internal reset release has passed. Random counts cover the full 0..63 range. Directed cases hit the counts 0, 1, 31, 32, 33 and 63 with sign-set operands, along with the unused kind code.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ALT = 2'b11
  } shift_kind_e;

  function automatic logic kind_is_left(input logic [1:0] k);
    return (k == SK_LSL) || (k == SK_ALT);
  endfunction
endpackage

// File: rtl/bshift_rstage.sv
// Logarithmic right shifter: one stage per count bit, shifting in a fill bit.
module bshift_rstage #(
  parameter int W  = 32,
  parameter int SW = 6
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          fill,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [SW+1];

  assign stg[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    if (S >= W) begin : g_flood
      assign stg[k+1] = amt[k] ? {W{fill}} : stg[k];
    end else begin : g_part
      assign stg[k+1] = amt[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
    end
  end

  assign dout = stg[SW];
endmodule

// File: rtl/bshift_carry.sv
// Picks the last bit moved out of the word; W must be a power of two.
module bshift_carry #(
  parameter int W  = 32,
  parameter int SW = 6
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  input  logic          cin,
  output logic          cout
);
  localparam int IW = $clog2(W);

  logic [IW-1:0] idx;
  logic          beyond;

  always_comb begin
    idx    = IW'(amt - SW'(1));
    beyond = (amt > SW'(W));
    if (amt == '0) begin
      cout = cin;
    end else if (beyond) begin
      cout = arith & din[W-1];
    end else if (left) begin
      cout = din[~idx];
    end else begin
      cout = din[idx];
    end
  end
endmodule

// File: rtl/bshift_flags.sv
module bshift_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  output logic         n_f,
  output logic         z_f
);
  assign n_f = res[W-1];
  assign z_f = (res == '0);
endmodule

// File: rtl/bshift_top.sv
module bshift_top #(
  parameter int W  = 32,
  parameter int SW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [W-1:0]  operand,
  input  logic [SW-1:0] count,
  input  logic [1:0]    kind,
  input  logic          carry_in,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          carry,
  output logic          extend,
  output logic          neg,
  output logic          zero,
  output logic          ovf
);
  import bshift_pkg::*;

  // reset: asserted at once, released on a clock edge
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // datapath
  logic         is_left, is_arith, fill;
  logic [W-1:0] pre, post, shv;
  logic         c_comb, n_comb, z_comb;

  assign is_left  = kind_is_left(kind);
  assign is_arith = (kind == SK_ASR);
  assign fill     = is_arith & operand[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign pre[i] = is_left ? operand[W-1-i] : operand[i];
    assign shv[i] = is_left ? post[W-1-i]    : post[i];
  end

  bshift_rstage #(.W(W), .SW(SW)) u_rs (
    .din(pre), .amt(count), .fill(fill), .dout(post)
  );

  bshift_carry #(.W(W), .SW(SW)) u_cy (
    .din(operand), .amt(count), .left(is_left), .arith(is_arith),
    .cin(carry_in), .cout(c_comb)
  );

  bshift_flags #(.W(W)) u_fl (
    .res(shv), .n_f(n_comb), .z_f(z_comb)
  );

  // next state
  logic [W-1:0] res_d, res_q;
  logic         c_d, c_q, x_d, x_q, n_d, n_q, z_d, z_q, vld_d, vld_q;

  always_comb begin
    vld_d = op_valid;
    res_d = res_q;
    c_d   = c_q;
    x_d   = x_q;
    n_d   = n_q;
    z_d   = z_q;
    if (op_valid) begin
      res_d = shv;
      c_d   = c_comb;
      x_d   = c_comb;
      n_d   = n_comb;
      z_d   = z_comb;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q <= 1'b0;
      res_q <= '0;
      c_q   <= 1'b0;
      x_q   <= 1'b0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      c_q   <= c_d;
      x_q   <= x_d;
      n_q   <= n_d;
      z_q   <= z_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign carry     = c_q;
  assign extend    = x_q;
  assign neg       = n_q;
  assign zero      = z_q;
  assign ovf       = 1'b0;

  // assertions
  assert_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && count == '0) |=> (result == $past(operand) && carry == $past(carry_in)));

  assert_big_logical_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && kind != SK_ASR && count > SW'(W)) |=> (result == '0 && !carry));

  assert_arith_flood_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (op_valid && kind == SK_ASR && count >= SW'(W))
      |=> (result == {W{$past(operand[W-1])}} && carry == $past(operand[W-1])));

  assert_extend_copy_R8: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> (extend == carry));

  assert_nz_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !(neg && zero));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !op_valid |=> ($stable(result) && $stable(carry) && !out_valid));
endmodule

// File: tb/bshift_top_bench.sv
module bshift_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [31:0] operand;
  logic [5:0]  count;
  logic [1:0]  kind;
  logic        carry_in;
  logic        out_valid;
  logic [31:0] result;
  logic        carry, extend, neg, zero, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bshift_top u_bshift_top (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .operand(operand),
    .count(count), .kind(kind), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .carry(carry), .extend(extend), .neg(neg),
    .zero(zero), .ovf(ovf)
  );

  // reference: returns {carry, result}
  function automatic logic [32:0] ref_shift(input logic [31:0] v, input logic [5:0] n,
                                             input logic [1:0] k, input logic ci);
    logic [63:0] ext;
    if (n == 0) return {ci, v};
    if (k == 2'b01) begin
      ext = {v, 32'h0} >> n;
      return {ext[31], ext[63:32]};
    end else if (k == 2'b10) begin
      ext = 64'($signed({v, 32'h0}) >>> n);
      return {ext[31], ext[63:32]};
    end else begin
      ext = {32'h0, v} << n;
      return {ext[32], ext[31:0]};
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] got_r, input logic got_c,
                       input logic [31:0] exp_r, input logic exp_c);
    checks++;
    if (got_r !== exp_r || got_c !== exp_c) begin
      errors++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               tag, got_r, got_c, exp_r, exp_c);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] v, input logic [5:0] n,
                     input logic [1:0] k, input logic ci);
    logic [32:0] e;
    e = ref_shift(v, n, k, ci);
    @(negedge clk);
    operand = v; count = n; kind = k; carry_in = ci; op_valid = 1'b1;
    @(posedge clk); #1;
    check(tag, result, carry, e[31:0], e[32]);
    checks++;
    if (extend !== carry || neg !== e[31] || zero !== (e[31:0] == 0) || ovf !== 1'b0
        || out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R8/R9/R10 %s: x=%b n=%b z=%b v=%b ov=%b expected x=%b n=%b z=%b v=0 ov=1",
               tag, extend, neg, zero, ovf, out_valid, e[32], e[31], (e[31:0] == 0));
    end
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_r;
    logic        held_c;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; op_valid = 1'b0; operand = '0; count = '0; kind = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({out_valid, result, carry, extend, neg, zero, ovf} !== '0) begin
      errors++;
      $display("FAIL R11: outputs=%h expected 0",
               {out_valid, result, carry, extend, neg, zero, ovf});
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2 zero count
    run("R2 lsl cnt0 cin1", 32'h8000_0001, 6'd0, 2'b00, 1'b1);
    run("R2 asr cnt0 cin0", 32'hFFFF_FFFF, 6'd0, 2'b10, 1'b0);
    // R3 left
    run("R3 lsl 1", 32'h8000_0001, 6'd1, 2'b00, 1'b0);
    run("R3 lsl 31", 32'h0000_0003, 6'd31, 2'b00, 1'b0);
    // R4 logical right
    run("R4 lsr 1", 32'h8000_0001, 6'd1, 2'b01, 1'b0);
    run("R4 lsr 31", 32'hC000_0000, 6'd31, 2'b01, 1'b0);
    // R5 count 32
    run("R5 lsl 32", 32'h0000_0001, 6'd32, 2'b00, 1'b0);
    run("R5 lsr 32", 32'h8000_0000, 6'd32, 2'b01, 1'b0);
    // R6 beyond 32
    run("R6 lsl 33", 32'hFFFF_FFFF, 6'd33, 2'b00, 1'b1);
    run("R6 lsr 63", 32'hFFFF_FFFF, 6'd63, 2'b01, 1'b1);
    // R7 arithmetic
    run("R7 asr 4 neg", 32'h8000_0008, 6'd4, 2'b10, 1'b0);
    run("R7 asr 32 neg", 32'h8000_0000, 6'd32, 2'b10, 1'b0);
    run("R7 asr 63 pos", 32'h7FFF_FFFF, 6'd63, 2'b10, 1'b1);
    // R1 alternate code behaves as left
    run("R1 alt 5", 32'h0800_0000, 6'd5, 2'b11, 1'b0);
    run("R1 alt 32", 32'h0000_0001, 6'd32, 2'b11, 1'b0);

    // R10 hold while idle
    held_r = result; held_c = carry;
    @(negedge clk);
    operand = 32'h1234_5678; count = 6'd3; kind = 2'b01; carry_in = ~held_c;
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (result !== held_r || carry !== held_c || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: result=%h carry=%b valid=%b expected result=%h carry=%b valid=0",
               result, carry, out_valid, held_r, held_c);
    end

    // random mix, R3..R7 by category
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v;
      logic [5:0]  n;
      logic [1:0]  k;
      v = $urandom;
      n = 6'($urandom);
      k = 2'($urandom);
      run("R3-7 random", v, n, k, 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule